// File: doc/BRIEF.md
# Three-Channel System Interval Timer

This block holds three 16-bit down-counters that share one slow count enable, derived by dividing the fast oscillator clock by a fixed ratio (12 by default, which turns 14.31818 MHz into about 1.193 MHz). Each channel has a fixed job. Channel 0 drives the system timer interrupt line. Channel 1 produces a refresh toggle that software reads through a status port. Channel 2 produces a speaker tone, and the tone reaches the pin only while software has enabled it in the same status port.

Software picks each channel's mode through a control byte and then writes a count as two bytes, low byte first. Two modes exist. The rate generator gives one low count period per cycle. The square-wave mode gives a near-symmetric square wave whose period is the initial count. A new count starts at the first count-enable tick after its high byte has been written.

Top module: `sys_interval_timer`

## Requirements
- R1: Counting advances only on a count tick, which occurs once every DIV oscillator clocks. Between ticks no channel output changes, except when a control byte is written.
- R2: After synchronous reset, all three channel outputs are high and idle. Speaker enable is 0, so `spk_out` is 0, `irq_timer` is 1 and `stat_rdata` reads 0x10.
- R3: A control byte is written to `tmr_addr`=3. Bits 7:6 select the channel (0, 1 or 2; the value 3 is ignored). Bit 0 selects the mode (0 = rate generator, 1 = square wave). The write forces the selected output high, stops that channel and resets its byte order to low-first.
- R4: Count bytes are written to `tmr_addr`=channel number, low byte first and then high byte. A low byte alone changes nothing. The count loads at the first tick after the high byte, and the output is high at that point.
- R5: In rate-generator mode with count N (N ≥ 2), the output goes low for exactly one tick when the count reaches 1. It is high again on the next tick, when N is reloaded, so the period is N ticks.
- R6: In square-wave mode with an even count N, the output is high for N/2 ticks and then low for N/2 ticks, repeating.
- R7: In square-wave mode with an odd count N ≥ 3, the output is high for (N+1)/2 ticks and low for (N-1)/2 ticks.
- R8: A written count of 0 is treated as 65536, so in square-wave mode each phase lasts 32768 ticks.
- R9: `irq_timer` follows the output of channel 0.
- R10: `stat_rdata` bit 4 shows the output of channel 1, and bit 1 reads back the speaker enable. All other bits read 0.
- R11: A status write sets the speaker enable from `stat_wdata` bit 1. `spk_out` is the channel 2 output while the enable is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_wr | input | 1 | Timer register write strobe |
| tmr_addr | input | 2 | 0–2 count byte of that channel, 3 control byte |
| tmr_wdata | input | 8 | Timer write data |
| stat_wr | input | 1 | Status port write strobe |
| stat_wdata | input | 8 | Status write data (bit 1 = speaker enable) |
| stat_rdata | output | 8 | Status read data |
| irq_timer | output | 1 | System timer interrupt line (channel 0) |
| spk_out | output | 1 | Gated speaker tone (channel 2) |

## Verification
The hardest case to reach from the ports is the count of 0 meaning 65536, because one phase then lasts 32768 ticks. The bench therefore builds the timer with a divide ratio of 3 and runs channel 0 in square-wave mode through a full high phase and into the low phase. A per-clock model checks the exact tick at which the phase flips. The bench also rewrites a count and a control byte while a channel is running, and writes a control byte with the unused channel select, to check that each of these takes effect or has no effect at the right tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W  = 16;
    localparam int FULL_W = CNT_W + 1;

    typedef enum logic {
        MODE_RATE   = 1'b0,
        MODE_SQUARE = 1'b1
    } tmr_mode_e;

    typedef struct packed {
        tmr_mode_e           mode;
        logic                run;
        logic                pend;
        logic                hi_next;
        logic                out;
        logic [7:0]          lo;
        logic [CNT_W-1:0]    init;
        logic [FULL_W-1:0]   cnt;
    } ch_state_t;

    // A written count of zero stands for the full 2**CNT_W range.
    function automatic logic [FULL_W-1:0] full_count(input logic [CNT_W-1:0] c);
        return (c == '0) ? (FULL_W'(1) << CNT_W) : FULL_W'(c);
    endfunction

    // Square-wave phase value, counted down by two per tick.
    // An odd count gives the extra tick to the high phase.
    function automatic logic [FULL_W-1:0] sq_len(input logic [FULL_W-1:0] n, input logic high);
        return high ? (n + FULL_W'(n[0])) : (n - FULL_W'(n[0]));
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] pcnt;

    assign tick = (pcnt == PW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst)       pcnt <= '0;
        else if (tick) pcnt <= '0;
        else           pcnt <= pcnt + 1'b1;
    end

    // R1: a tick is followed by at least one quiet clock when the ratio exceeds one
    p_tick_spacing_r1: assert property (@(posedge clk) disable iff (rst)
        (tick && DIV > 1) |=> !tick);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       ctl_wr,
    input  tmr_mode_e  ctl_mode,
    input  logic       byte_wr,
    input  logic [7:0] byte_data,
    output logic       out_o
);
    ch_state_t q, d;
    logic [FULL_W-1:0] n;

    assign n     = full_count(q.init);
    assign out_o = q.out;

    always_comb begin
        d = q;
        if (tick) begin
            if (q.pend) begin
                d.cnt  = (q.mode == MODE_SQUARE) ? sq_len(n, 1'b1) : n;
                d.out  = 1'b1;
                d.run  = 1'b1;
                d.pend = 1'b0;
            end else if (q.run) begin
                if (q.mode == MODE_RATE) begin
                    if (q.cnt == FULL_W'(1)) begin
                        d.cnt = n;
                        d.out = 1'b1;
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                        d.out = (q.cnt != FULL_W'(2));
                    end
                end else begin
                    if (q.cnt <= FULL_W'(2)) begin
                        d.out = !q.out;
                        d.cnt = sq_len(n, !q.out);
                    end else begin
                        d.cnt = q.cnt - FULL_W'(2);
                    end
                end
            end
        end
        if (byte_wr) begin
            if (!q.hi_next) begin
                d.lo      = byte_data;
                d.hi_next = 1'b1;
            end else begin
                d.init    = {byte_data, q.lo};
                d.hi_next = 1'b0;
                d.pend    = 1'b1;
            end
        end
        if (ctl_wr) begin
            d.mode    = ctl_mode;
            d.run     = 1'b0;
            d.pend    = 1'b0;
            d.hi_next = 1'b0;
            d.out     = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q         <= '0;
            q.mode    <= MODE_RATE;
            q.out     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // R1: the output holds between ticks unless a control byte arrives
    p_out_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ctl_wr) |=> $stable(out_o));

    // R3: a control byte leaves the channel stopped with its output high
    p_ctl_idle_r3: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (!q.run && !q.pend && out_o));

    // R4: a pending count starts on the tick with the output high
    p_load_high_r4: assert property (@(posedge clk) disable iff (rst)
        (q.pend && tick && !ctl_wr) |=> (q.run && out_o));

    // R5: the rate-generator low pulse lasts a single tick
    p_rate_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (q.mode == MODE_RATE && !out_o && tick && !ctl_wr) |=> out_o);

    // R8: a running square-wave phase value never drops below two
    p_sq_range_r8: assert property (@(posedge clk) disable iff (rst)
        (q.run && q.mode == MODE_SQUARE) |-> (q.cnt >= FULL_W'(2)));

endmodule

// File: rtl/sys_interval_timer.sv
module sys_interval_timer
    import tmr_pkg::*;
#(
    parameter int DIV   = 12,
    parameter int N_CH  = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tmr_wr,
    input  logic [1:0] tmr_addr,
    input  logic [7:0] tmr_wdata,
    input  logic       stat_wr,
    input  logic [7:0] stat_wdata,
    output logic [7:0] stat_rdata,
    output logic       irq_timer,
    output logic       spk_out
);
    localparam logic [1:0] CTL_ADDR = 2'd3;

    logic            tick;
    logic [N_CH-1:0] ch_out;
    logic            spk_en;

    tmr_prescale #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic ctl_sel, byte_sel;
        assign ctl_sel  = tmr_wr && (tmr_addr == CTL_ADDR) && (tmr_wdata[7:6] == 2'(i));
        assign byte_sel = tmr_wr && (tmr_addr == 2'(i));

        tmr_channel u_ch (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick),
            .ctl_wr    (ctl_sel),
            .ctl_mode  (tmr_mode_e'(tmr_wdata[0])),
            .byte_wr   (byte_sel),
            .byte_data (tmr_wdata),
            .out_o     (ch_out[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)          spk_en <= 1'b0;
        else if (stat_wr) spk_en <= stat_wdata[1];
    end

    assign irq_timer  = ch_out[0];
    assign spk_out    = ch_out[2] & spk_en;
    assign stat_rdata = {3'b000, ch_out[1], 2'b00, spk_en, 1'b0};

    // R11: a status write with bit 1 clear silences the speaker on the next clock
    p_spk_off_r11: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !stat_wdata[1]) |=> !spk_out);

endmodule

// File: tb/sys_interval_timer_tb_top.sv
module sys_interval_timer_tb_top;

    localparam int DIV = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tmr_wr = 1'b0;
    logic [1:0] tmr_addr = '0;
    logic [7:0] tmr_wdata = '0;
    logic       stat_wr = 1'b0;
    logic [7:0] stat_wdata = '0;
    logic [7:0] stat_rdata;
    logic       irq_timer;
    logic       spk_out;

    always #4 clk = ~clk;

    sys_interval_timer #(.DIV(DIV)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .tmr_wr     (tmr_wr),
        .tmr_addr   (tmr_addr),
        .tmr_wdata  (tmr_wdata),
        .stat_wr    (stat_wr),
        .stat_wdata (stat_wdata),
        .stat_rdata (stat_rdata),
        .irq_timer  (irq_timer),
        .spk_out    (spk_out)
    );

    int checks = 0;
    int failures = 0;
    string cur_req = "R2";

    // behavioural reference model
    int m_pc;
    int m_mode[3];
    int m_run[3];
    int m_pend[3];
    int m_hin[3];
    int m_lo[3];
    int m_init[3];
    int m_out[3];
    int m_rem[3];
    int m_spk;

    function automatic int full_n(int v);
        return (v == 0) ? 65536 : v;
    endfunction

    task automatic model_reset();
        m_pc = 0;
        m_spk = 0;
        for (int c = 0; c < 3; c++) begin
            m_mode[c] = 0; m_run[c] = 0; m_pend[c] = 0; m_hin[c] = 0;
            m_lo[c] = 0; m_init[c] = 0; m_out[c] = 1; m_rem[c] = 0;
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            model_reset();
        end else begin
            automatic bit tk = (m_pc == DIV - 1);
            m_pc = tk ? 0 : m_pc + 1;
            for (int c = 0; c < 3; c++) begin
                automatic int nn = full_n(m_init[c]);
                if (tk) begin
                    if (m_pend[c] != 0) begin
                        m_pend[c] = 0; m_run[c] = 1; m_out[c] = 1;
                        m_rem[c] = (m_mode[c] == 1) ? (nn + 1) / 2 : nn;
                    end else if (m_run[c] != 0) begin
                        if (m_mode[c] == 0) begin
                            if (m_rem[c] == 1) begin m_rem[c] = nn; m_out[c] = 1; end
                            else begin m_rem[c]--; m_out[c] = (m_rem[c] == 1) ? 0 : 1; end
                        end else begin
                            if (m_rem[c] == 1) begin
                                m_out[c] = 1 - m_out[c];
                                m_rem[c] = (m_out[c] == 1) ? (nn + 1) / 2 : nn / 2;
                            end else m_rem[c]--;
                        end
                    end
                end
                if (tmr_wr && tmr_addr == 2'(c)) begin
                    if (m_hin[c] == 0) begin m_lo[c] = int'(tmr_wdata); m_hin[c] = 1; end
                    else begin m_init[c] = int'(tmr_wdata) * 256 + m_lo[c]; m_hin[c] = 0; m_pend[c] = 1; end
                end
                if (tmr_wr && tmr_addr == 2'd3 && int'(tmr_wdata[7:6]) == c) begin
                    m_mode[c] = int'(tmr_wdata[0]); m_run[c] = 0; m_pend[c] = 0;
                    m_hin[c] = 0; m_out[c] = 1;
                end
            end
            if (stat_wr) m_spk = int'(stat_wdata[1]);
        end
    end

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            if (failures <= 30)
                $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("irq_timer", int'(irq_timer), m_out[0]);
            chk("stat_rdata", int'(stat_rdata), m_out[1] * 16 + m_spk * 2);
            chk("spk_out", int'(spk_out), m_out[2] * m_spk);
        end
    end

    task automatic twr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        tmr_wr = 1'b1; tmr_addr = a; tmr_wdata = d;
        @(negedge clk);
        tmr_wr = 1'b0;
    endtask

    task automatic swr(logic [7:0] d);
        @(negedge clk);
        stat_wr = 1'b1; stat_wdata = d;
        @(negedge clk);
        stat_wr = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog %s actual=running expected=done", cur_req);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R2: reset values seen at the ports
        cur_req = "R2";
        chk("reset irq", int'(irq_timer), 1);
        chk("reset stat", int'(stat_rdata), 8'h10);
        chk("reset spk", int'(spk_out), 0);
        idle(10);

        // R1 R5 R10: channel 1 rate generator, count 5
        cur_req = "R1/R5/R10";
        twr(2'd3, 8'h40);
        twr(2'd1, 8'd5);
        twr(2'd1, 8'd0);
        idle(80);

        // R6 R9: channel 0 square wave, count 6
        cur_req = "R6/R9";
        twr(2'd3, 8'h01);
        twr(2'd0, 8'd6);
        twr(2'd0, 8'd0);
        idle(90);

        // R7 R11: channel 2 square wave, count 7, speaker gated off then on
        cur_req = "R7/R11";
        twr(2'd3, 8'h81);
        twr(2'd2, 8'd7);
        twr(2'd2, 8'd0);
        idle(60);
        swr(8'h02);
        idle(90);
        swr(8'h00);
        idle(20);

        // R3: select value 3 is ignored; a control byte stops channel 0
        cur_req = "R3";
        twr(2'd3, 8'hC0);
        idle(30);
        twr(2'd3, 8'h00);
        idle(40);

        // R4: low byte alone has no effect; high byte starts counting
        cur_req = "R4";
        twr(2'd0, 8'd4);
        idle(40);
        twr(2'd0, 8'd0);
        idle(60);
        // R4: new count while running on channel 1
        twr(2'd1, 8'd3);
        twr(2'd1, 8'd0);
        idle(60);

        // R8: count 0 means 65536 in square-wave mode on channel 0
        cur_req = "R8";
        twr(2'd3, 8'h01);
        twr(2'd0, 8'd0);
        twr(2'd0, 8'd0);
        idle(32768 * DIV + 300);

        finish_run();
    end

endmodule